// File: doc/BRIEF.md
# Memory Protection Region Register Bank

This block stores the per-region settings of a physical memory protection unit and serves them to the core's control-register port. Each region owns one 8-bit configuration byte and one address word. The bank decodes the 12-bit register number of an access and checks that the requester runs at machine privilege. It returns read data in the same cycle and commits writes on the next clock edge. All stored bytes and words are also driven out in flat vectors, for the matching logic that sits beside it.

The register width is a parameter, 32 or 64 bits. It changes how the configuration bytes are packed into register words and how many address bits a region keeps. The number of implemented regions is also a parameter, 0, 16 or 64. Registers of regions that are not implemented still decode, but they hold zero. With no regions implemented, the bank claims no register number at all.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset every configuration byte and every address word, on the outputs and on reads, is zero.
- R2: In 32-bit mode, configuration register 0x3A0+i (i = 0..15) holds regions 4i..4i+3, with region 4i+j in bits 8j+7:8j.
- R3: In 64-bit mode, configuration register 0x3A0+2k (k = 0..7) holds regions 8k..8k+7, with region 8k+j in bits 8j+7:8j.
- R4: In 64-bit mode, any access to an odd configuration register (0x3A1, 0x3A3, .. 0x3AF) raises the illegal flag, reads zero and changes no state.
- R5: Address register 0x3B0+n belongs to region n (n = 0..63). In 32-bit mode it keeps all 32 written bits.
- R6: In 64-bit mode an address register keeps written bits 53:0, and bits 63:54 read as zero.
- R7: An access to any bank register at a privilege other than machine (priv encoding 2'b11) raises the illegal flag, reads zero and changes no state.
- R8: Registers of unimplemented regions, such as configuration registers 0x3A4..0x3AF and address registers 0x3C0..0x3EF with 16 regions, decode with hit high and illegal low, read zero, and ignore writes.
- R9: With 0 regions, no register number hits, the illegal flag stays low and read data is zero.
- R10: A write takes effect at the clock edge where enable, write strobe and hit are high and illegal is low. It is visible on the outputs and on reads from the next cycle. Reads are combinational, and an access with the write strobe low changes nothing.
- R11: Register numbers outside 0x3A0..0x3EF give hit low, illegal low and read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en_i | input | 1 | Access valid this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | Register number |
| csr_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Current privilege level, 2'b11 is machine |
| csr_hit_o | output | 1 | Register number belongs to this bank |
| csr_illegal_o | output | 1 | Access must trap |
| csr_rdata_o | output | XLEN | Read data, zero unless a legal hit |
| pmp_cfg_o | output | 512 | Region r configuration byte at bits 8r+7:8r |
| pmp_addr_o | output | 64*XLEN | Region r address word at bits XLEN*r+XLEN-1:XLEN*r |

## Verification
A wrong byte lane or a wrong region index appears at two places one cycle after the write: in the flat configuration vector, and in the read data of a neighbouring register. Sweeping every register with a pattern that is distinct per byte exposes it within one pass. A missed illegal check shows as a flag low in the same cycle, and as a changed output in the cycle after the write. Decoding that is too wide or too narrow shows in a full sweep of all 4096 register numbers.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

    localparam int          MAX_REGIONS = 64;
    localparam logic [11:0] CFG_BASE    = 12'h3A0;
    localparam logic [11:0] ADDR_BASE   = 12'h3B0;
    localparam logic [11:0] ADDR_LAST   = 12'h3EF;
    localparam logic [1:0]  PRIV_M      = 2'b11;

    typedef struct packed {
        logic       hit;
        logic       illegal;
        logic       is_cfg;
        logic       is_addr;
        logic       wr;
        logic [3:0] cfg_idx;
        logic [5:0] addr_idx;
    } csr_dec_t;

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
    import pmp_csr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_REGIONS = 64
) (
    input  logic        en_i,
    input  logic        we_i,
    input  logic [11:0] addr_i,
    input  logic [1:0]  priv_i,
    output csr_dec_t    dec_o
);

    localparam bit WIDE    = (XLEN == 64);
    localparam bit PRESENT = (NUM_REGIONS != 0);

    logic        in_cfg;
    logic        in_addr;
    logic        odd_bad;
    logic [11:0] addr_off;

    always_comb begin
        in_cfg   = (addr_i[11:4] == CFG_BASE[11:4]);
        in_addr  = (addr_i >= ADDR_BASE) && (addr_i <= ADDR_LAST);
        addr_off = addr_i - ADDR_BASE;
        odd_bad  = WIDE && in_cfg && addr_i[0];

        dec_o          = '0;
        dec_o.is_cfg   = PRESENT && in_cfg;
        dec_o.is_addr  = PRESENT && in_addr;
        dec_o.hit      = dec_o.is_cfg || dec_o.is_addr;
        dec_o.illegal  = en_i && dec_o.hit && ((priv_i != PRIV_M) || odd_bad);
        dec_o.wr       = en_i && we_i && dec_o.hit && !dec_o.illegal;
        dec_o.cfg_idx  = addr_i[3:0];
        dec_o.addr_idx = addr_off[5:0];
    end

endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
    import pmp_csr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_REGIONS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [3:0]               csr_idx_i,
    input  logic [XLEN-1:0]          wdata_i,
    output logic [XLEN-1:0]          rdata_o,
    output logic [MAX_REGIONS*8-1:0] cfg_o
);

    localparam int LANES     = XLEN / 8;
    localparam int IDX_SCALE = LANES / 4;

    typedef struct packed {
        logic [MAX_REGIONS-1:0][7:0] cfg;
    } cfg_state_t;

    cfg_state_t st_d;
    cfg_state_t st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < MAX_REGIONS; r++) begin
            if (r >= NUM_REGIONS) begin
                st_d.cfg[r] = '0;
            end else if (wr_en_i && ((r / LANES) == (int'(csr_idx_i) / IDX_SCALE))) begin
                st_d.cfg[r] = wdata_i[(r % LANES)*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [6:0] rd_region;

    always_comb begin
        rdata_o   = '0;
        rd_region = '0;
        for (int j = 0; j < LANES; j++) begin
            rd_region = {1'b0, csr_idx_i, 2'b00} + 7'(j);
            if (rd_region < 7'(MAX_REGIONS)) begin
                rdata_o[j*8 +: 8] = st_q.cfg[rd_region[5:0]];
            end
        end
    end

    assign cfg_o = st_q.cfg;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q)) else $error("cfg changed without write"); // R10

endmodule

// File: rtl/pmp_addr_bank.sv
module pmp_addr_bank
    import pmp_csr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_REGIONS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [5:0]                  idx_i,
    input  logic [XLEN-1:0]             wdata_i,
    output logic [XLEN-1:0]             rdata_o,
    output logic [MAX_REGIONS*XLEN-1:0] addr_o
);

    localparam int ADDR_W = (XLEN == 64) ? 54 : 32;

    typedef struct packed {
        logic [MAX_REGIONS-1:0][ADDR_W-1:0] addr;
    } addr_state_t;

    addr_state_t st_d;
    addr_state_t st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < MAX_REGIONS; r++) begin
            if (r >= NUM_REGIONS) begin
                st_d.addr[r] = '0;
            end else if (wr_en_i && (int'(idx_i) == r)) begin
                st_d.addr[r] = wdata_i[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (ADDR_W < XLEN) begin : g_pad
            for (genvar r = 0; r < MAX_REGIONS; r++) begin : g_out
                assign addr_o[r*XLEN +: XLEN] = {{(XLEN-ADDR_W){1'b0}}, st_q.addr[r]};
            end
            assign rdata_o = {{(XLEN-ADDR_W){1'b0}}, st_q.addr[idx_i]};
        end else begin : g_full
            for (genvar r = 0; r < MAX_REGIONS; r++) begin : g_out
                assign addr_o[r*XLEN +: XLEN] = st_q.addr[r];
            end
            assign rdata_o = st_q.addr[idx_i];
        end
    endgenerate

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q)) else $error("addr changed without write"); // R10

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_csr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NUM_REGIONS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_en_i,
    input  logic                        csr_we_i,
    input  logic [11:0]                 csr_addr_i,
    input  logic [XLEN-1:0]             csr_wdata_i,
    input  logic [1:0]                  priv_i,
    output logic                        csr_hit_o,
    output logic                        csr_illegal_o,
    output logic [XLEN-1:0]             csr_rdata_o,
    output logic [MAX_REGIONS*8-1:0]    pmp_cfg_o,
    output logic [MAX_REGIONS*XLEN-1:0] pmp_addr_o
);

    localparam int              ADDR_W    = (XLEN == 64) ? 54 : 32;
    localparam logic [XLEN-1:0] ADDR_MASK = {XLEN{1'b1}} >> (XLEN - ADDR_W);

    initial begin
        assert ((XLEN == 32) || (XLEN == 64)) else $error("XLEN must be 32 or 64");
        assert ((NUM_REGIONS == 0) || (NUM_REGIONS == 16) || (NUM_REGIONS == 64))
            else $error("NUM_REGIONS must be 0, 16 or 64");
    end

    csr_dec_t        dec;
    logic [XLEN-1:0] cfg_rd;
    logic [XLEN-1:0] addr_rd;

    pmp_csr_decode #(.XLEN(XLEN), .NUM_REGIONS(NUM_REGIONS)) u_decode (
        .en_i   (csr_en_i),
        .we_i   (csr_we_i),
        .addr_i (csr_addr_i),
        .priv_i (priv_i),
        .dec_o  (dec)
    );

    pmp_cfg_bank #(.XLEN(XLEN), .NUM_REGIONS(NUM_REGIONS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (dec.wr && dec.is_cfg),
        .csr_idx_i (dec.cfg_idx),
        .wdata_i   (csr_wdata_i),
        .rdata_o   (cfg_rd),
        .cfg_o     (pmp_cfg_o)
    );

    pmp_addr_bank #(.XLEN(XLEN), .NUM_REGIONS(NUM_REGIONS)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (dec.wr && dec.is_addr),
        .idx_i   (dec.addr_idx),
        .wdata_i (csr_wdata_i),
        .rdata_o (addr_rd),
        .addr_o  (pmp_addr_o)
    );

    always_comb begin
        csr_hit_o     = dec.hit;
        csr_illegal_o = dec.illegal;
        csr_rdata_o   = '0;
        if (csr_en_i && dec.hit && !dec.illegal) begin
            if (dec.is_cfg) begin
                csr_rdata_o = cfg_rd;
            end else begin
                csr_rdata_o = addr_rd;
            end
        end
    end

    logic in_range;
    assign in_range = (csr_addr_i >= CFG_BASE) && (csr_addr_i <= ADDR_LAST);

    AST_LOW_PRIV_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en_i && csr_hit_o && (priv_i != PRIV_M) |-> csr_illegal_o)
        else $error("low privilege access not flagged"); // R7

    AST_ODD_CFG_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (XLEN == 64) && csr_en_i && csr_hit_o && (csr_addr_i[11:4] == 8'h3A) && csr_addr_i[0]
        |-> csr_illegal_o) else $error("odd cfg access not flagged"); // R4

    AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal_o |=> $stable(pmp_cfg_o) && $stable(pmp_addr_o))
        else $error("illegal access changed state"); // R7

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en_i && !in_range |-> !csr_hit_o && !csr_illegal_o && (csr_rdata_o == '0))
        else $error("foreign register number claimed"); // R11

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        csr_en_i && (csr_addr_i >= ADDR_BASE) |-> ((csr_rdata_o & ~ADDR_MASK) == '0))
        else $error("address upper bits not zero"); // R6

    AST_ADDR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wr && dec.is_addr && (int'(dec.addr_idx) < NUM_REGIONS)
        |=> pmp_addr_o[$past(dec.addr_idx)*XLEN +: XLEN] == ($past(csr_wdata_i) & ADDR_MASK))
        else $error("address write lost"); // R10

endmodule

// File: tb/pmp_csr_bank_tb.sv
module pmp_csr_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  priv = 2'b11;

    logic          hit64, ill64, hit32, ill32, hit0, ill0;
    logic [63:0]   rd64, rd0;
    logic [31:0]   rd32;
    logic [511:0]  cfg64, cfg32, cfg0;
    logic [4095:0] av64, av0;
    logic [2047:0] av32;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  m64_cfg  [64];
    logic [63:0] m64_addr [64];
    logic [7:0]  m32_cfg  [64];
    logic [31:0] m32_addr [64];

    always #5 clk = ~clk;

    pmp_csr_bank #(.XLEN(64), .NUM_REGIONS(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_en_i(en), .csr_we_i(we), .csr_addr_i(addr),
        .csr_wdata_i(wdata), .priv_i(priv), .csr_hit_o(hit64), .csr_illegal_o(ill64),
        .csr_rdata_o(rd64), .pmp_cfg_o(cfg64), .pmp_addr_o(av64));

    pmp_csr_bank #(.XLEN(32), .NUM_REGIONS(16)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .csr_en_i(en), .csr_we_i(we), .csr_addr_i(addr),
        .csr_wdata_i(wdata[31:0]), .priv_i(priv), .csr_hit_o(hit32), .csr_illegal_o(ill32),
        .csr_rdata_o(rd32), .pmp_cfg_o(cfg32), .pmp_addr_o(av32));

    pmp_csr_bank #(.XLEN(64), .NUM_REGIONS(0)) u_dut0 (
        .clk(clk), .rst_n(rst_n), .csr_en_i(en), .csr_we_i(we), .csr_addr_i(addr),
        .csr_wdata_i(wdata), .priv_i(priv), .csr_hit_o(hit0), .csr_illegal_o(ill0),
        .csr_rdata_o(rd0), .pmp_cfg_o(cfg0), .pmp_addr_o(av0));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: addr %h actual %h expected %h", tag, addr, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [11:0] a, input logic [63:0] d, input logic [1:0] p);
        bit in_cfg, in_ad, h, i64, i32;
        logic [63:0] e64;
        logic [31:0] e32;
        int r;
        string t64, t32;
        @(negedge clk);
        en = 1'b1; we = w; addr = a; wdata = d; priv = p;
        #1;
        in_cfg = (a >= 12'h3A0) && (a <= 12'h3AF);
        in_ad  = (a >= 12'h3B0) && (a <= 12'h3EF);
        h   = in_cfg || in_ad;
        i64 = h && ((p != 2'b11) || (in_cfg && a[0]));
        i32 = h && (p != 2'b11);
        e64 = '0; e32 = '0;
        r = int'(a) - 'h3B0;
        if (!h) begin t64 = "R11"; t32 = "R11"; end
        else if (p != 2'b11) begin t64 = "R7"; t32 = "R7"; end
        else if (in_cfg) begin
            t64 = a[0] ? "R4" : "R3";
            t32 = (a[3:0] < 4) ? "R2" : "R8";
            if (!a[0]) for (int j = 0; j < 8; j++) e64[j*8 +: 8] = m64_cfg[(int'(a[3:0]) / 2) * 8 + j];
            for (int j = 0; j < 4; j++) e32[j*8 +: 8] = m32_cfg[int'(a[3:0]) * 4 + j];
        end else begin
            t64 = "R6";
            t32 = (r < 16) ? "R5" : "R8";
            e64 = m64_addr[r];
            e32 = m32_addr[r];
        end
        if (i64) e64 = '0;
        if (i32) e32 = '0;
        chk(hit64 == h, t64, 64'(hit64), 64'(h));
        chk(ill64 == i64, t64, 64'(ill64), 64'(i64));
        chk(rd64 == e64, t64, rd64, e64);
        chk(hit32 == h, t32, 64'(hit32), 64'(h));
        chk(ill32 == i32, t32, 64'(ill32), 64'(i32));
        chk(rd32 == e32, t32, 64'(rd32), 64'(e32));
        chk(!hit0 && !ill0 && rd0 == '0, "R9", {hit0, ill0, rd0[61:0]}, 64'd0);
        @(posedge clk);
        #1;
        en = 1'b0; we = 1'b0;
        if (w && !i64) begin
            if (in_cfg) for (int j = 0; j < 8; j++) m64_cfg[(int'(a[3:0]) / 2) * 8 + j] = d[j*8 +: 8];
            if (in_ad) m64_addr[r] = d & ((64'd1 << 54) - 64'd1);
        end
        if (w && !i32) begin
            if (in_cfg) for (int j = 0; j < 4; j++)
                if (int'(a[3:0]) * 4 + j < 16) m32_cfg[int'(a[3:0]) * 4 + j] = d[j*8 +: 8];
            if (in_ad && r < 16) m32_addr[r] = d[31:0];
        end
    endtask

    task automatic check_outputs(input string tag);
        @(negedge clk);
        for (int r = 0; r < 64; r++) begin
            chk(cfg64[r*8 +: 8] == m64_cfg[r], tag, 64'(cfg64[r*8 +: 8]), 64'(m64_cfg[r]));
            chk(av64[r*64 +: 64] == m64_addr[r], tag, av64[r*64 +: 64], m64_addr[r]);
            chk(cfg32[r*8 +: 8] == m32_cfg[r], tag, 64'(cfg32[r*8 +: 8]), 64'(m32_cfg[r]));
            chk(av32[r*32 +: 32] == m32_addr[r], tag, 64'(av32[r*32 +: 32]), 64'(m32_addr[r]));
        end
        chk(cfg0 == '0 && av0 == '0, "R9", 64'(|{cfg0, av0}), 64'd0);
    endtask

    function automatic logic [63:0] cfg_pat(input int i, input logic [7:0] s);
        logic [63:0] v;
        for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'((i * 8 + j) * 37) ^ s;
        return v;
    endfunction

    function automatic logic [63:0] addr_pat(input int i, input logic [63:0] s);
        return (64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0101_0203_0405_0607)) ^ s;
    endfunction

    initial begin
        for (int r = 0; r < 64; r++) begin
            m64_cfg[r] = '0; m64_addr[r] = '0; m32_cfg[r] = '0; m32_addr[r] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_outputs("R1");
        for (int i = 0; i < 16; i++) access(1'b0, 12'h3A0 + 12'(i), 64'h0, 2'b11);

        for (int i = 0; i < 16; i++) access(1'b1, 12'h3A0 + 12'(i), cfg_pat(i, 8'h5A), 2'b11);
        for (int i = 0; i < 16; i++) access(1'b0, 12'h3A0 + 12'(i), '1, 2'b11);
        for (int i = 0; i < 64; i++) access(1'b1, 12'h3B0 + 12'(i), addr_pat(i, 64'h0), 2'b11);
        for (int i = 0; i < 64; i++) access(1'b0, 12'h3B0 + 12'(i), '1, 2'b11);
        check_outputs("R10");

        for (int p = 0; p < 3; p++) begin
            access(1'b1, 12'h3A0, '1, 2'(p));
            access(1'b1, 12'h3A6, '1, 2'(p));
            access(1'b1, 12'h3B3, '1, 2'(p));
            access(1'b1, 12'h3EF, '1, 2'(p));
        end
        check_outputs("R7");

        for (int i = 0; i < 16; i++) access(1'b1, 12'h3A0 + 12'(i), cfg_pat(i, 8'hC3), 2'b11);
        for (int i = 0; i < 64; i += 3) access(1'b1, 12'h3B0 + 12'(i), addr_pat(i, 64'hFFFF_0000_FFFF_0000), 2'b11);
        check_outputs("R10");

        for (int a = 0; a < 4096; a++) access(1'b0, 12'(a), 64'hDEAD_BEEF_0BAD_F00D, 2'b11);
        check_outputs("R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule